// File: doc/BRIEF.md
# DMA Channel Bus-Mode Sequencer

This block sequences one DMA channel. Each transfer it runs is dual-address: one read bus cycle from the source address, then one write bus cycle that puts the read data at the destination address. The block also decides when the channel asks for the shared bus and when it hands the bus back. Software-side logic loads a start configuration: the addresses, a transfer count, a bus mode, a request source and an address stepping mode for each side. After that the channel runs on its own until the count reaches zero.

Three bus modes are available. Plain cycle steal gives the bus back after every transfer. The gapped variant of cycle steal also keeps the bus away from the channel for a fixed number of idle clocks after every transfer. Burst keeps the bus across transfers. A transfer can be triggered by an external active-low level request or by a pulse from an on-chip peripheral. Only a fixed set of on-chip sources may use burst. Any other on-chip source falls back to plain cycle steal.

Top module: `dma_seq_chan`

## Requirements
- R1: Each transfer issues one read command (cmd_write=0) at the source address and then one write command (cmd_write=1) at the destination address. The write carries the data returned by the read.
- R2: Address step codes are 0 fixed, 1 increment by STEP (4), and 2 decrement by STEP. The source address moves after its read completes. The destination address moves after its write completes.
- R3: count_left drops by one after each completed write. When it reaches zero, done_pulse is high for exactly one cycle, busy clears and bus_req goes low.
- R4: Mode code 0 (plain cycle steal) drops bus_req after every transfer. If the request is still active, bus_req stays low for exactly one cycle before it is raised again.
- R5: Mode code 1 (gapped) keeps bus_req low after each non-final transfer for GAP_SHORT (16) clocks when cfg_gap_long=0 and for GAP_LONG (64) clocks when cfg_gap_long=1. With a request waiting, bus_req rises again after exactly gap+1 low cycles.
- R6: Mode code 2 (burst) holds bus_req high from the first grant until the count reaches zero, as long as the request stays active.
- R7: In burst mode with the external request (cfg_req_ext=1), if ext_req_n goes high, the transfer already started is allowed to finish. The bus is then released with a nonzero count, and the channel resumes when ext_req_n goes low again.
- R8: An on-chip source whose id has its bit set in BURST_OK_MASK (default: ids 0 to 4) bursts the whole count on one request. Any other id with burst selected performs one transfer per request and releases the bus after each one.
- R9: The external request is an active-low level, sampled each time a transfer could start. An on-chip request is a rising edge on periph_req. The edge sets a pending flag, the flag is cleared when a transfer is accepted, and it is kept through a gapped-mode idle period.
- R10: A start with start_count=0, or a start while busy is high, is ignored.
- R11: A read or write command is presented only while bus_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load configuration and enable the channel |
| start_src | input | AW | Initial source address |
| start_dst | input | AW | Initial destination address |
| start_count | input | CW | Number of transfers |
| cfg_bus_mode | input | 2 | 0 cycle steal, 1 gapped, 2 burst |
| cfg_gap_long | input | 1 | Gap length select: 0 short, 1 long |
| cfg_req_ext | input | 1 | 1 external level request, 0 on-chip request |
| cfg_src_id | input | 3 | On-chip request source id |
| cfg_src_step | input | 2 | Source address step code |
| cfg_dst_step | input | 2 | Destination address step code |
| ext_req_n | input | 1 | External request, active low |
| periph_req | input | 1 | On-chip request, edge detected |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| cmd_valid | output | 1 | Bus command present |
| cmd_write | output | 1 | 1 write, 0 read |
| cmd_addr | output | AW | Command address |
| cmd_wdata | output | DW | Write data |
| cmd_ready | input | 1 | Command completes this cycle |
| rd_data | input | DW | Read data, valid with cmd_ready on a read |
| busy | output | 1 | Channel enabled |
| count_left | output | CW | Remaining transfers |
| done_pulse | output | 1 | One-cycle end-of-count pulse |

## Verification
The hardest case to reach is the early release in burst mode. The external level has to be removed while a transfer is already on the bus, so that the write still completes but the next read never starts. The bench watches the ports for the first read command and raises ext_req_n in that cycle. It then checks that exactly one write landed, that the count is still nonzero and that the bus has been released. The second awkward case is an on-chip pulse that arrives inside a gapped idle period. The bench triggers it a few clocks after a write and checks that the held request starts a transfer exactly when the gap expires.

// File: rtl/dma_seq_pkg.sv
// Shared encodings for the DMA channel sequencer.
// Assumes: all modules of the channel import this package.
package dma_seq_pkg;
    typedef enum logic [1:0] {
        BM_STEAL  = 2'd0,
        BM_GAPPED = 2'd1,
        BM_BURST  = 2'd2
    } bus_mode_e;

    typedef enum logic [1:0] {
        AS_FIXED = 2'd0,
        AS_INC   = 2'd1,
        AS_DEC   = 2'd2
    } addr_step_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARB   = 2'd1,
        SQ_READ  = 2'd2,
        SQ_WRITE = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_req_detect.sv
// Request front end. Selects between an active-low external level and an
// edge-detected on-chip pulse. The on-chip edge is kept as a pending flag
// until the sequencer accepts a transfer.
// Assumes: both request inputs are already synchronous to clk.
module dma_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_ext,
    input  logic ext_req_n,
    input  logic periph_req,
    input  logic accept,
    output logic req_active
);
    logic periph_q;
    logic pending_q;
    logic periph_edge;

    assign periph_edge = periph_req && !periph_q;

    // Remember the previous on-chip level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) periph_q <= 1'b0;
        else        periph_q <= periph_req;
    end

    // Pending flag: a new edge sets it, an accepted transfer clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)           pending_q <= 1'b0;
        else if (periph_edge) pending_q <= 1'b1;
        else if (accept)      pending_q <= 1'b0;
    end

    assign req_active = sel_ext ? !ext_req_n : pending_q;

    // R9: an edge always leaves a pending request behind.
    p_edge_sets_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        periph_edge |=> pending_q);
endmodule

// File: rtl/dma_gap_timer.sv
// Idle-gap timer for the gapped cycle-steal mode. It is loaded when the bus
// is released and counts down to zero. It reports active while counting.
// Assumes: GAP_LONG >= GAP_SHORT > 0.
module dma_gap_timer #(
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic long_sel,
    output logic active
);
    localparam int GW = $clog2(GAP_LONG + 1);
    localparam logic [GW-1:0] SHORT_V = GW'(GAP_SHORT);
    localparam logic [GW-1:0] LONG_V  = GW'(GAP_LONG);

    logic [GW-1:0] cnt_q;

    // Load on release, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= long_sel ? LONG_V : SHORT_V;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);

    // R5: the count never exceeds the longer setting.
    p_gap_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LONG_V);
endmodule

// File: rtl/dma_addr_step.sv
// One address register with load and a fixed, incrementing or decrementing
// step, moved once per completed bus cycle on its side.
// Assumes: step and load are never high in the same cycle.
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  addr_step_e    mode,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Hold, load or step the address.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr <= '0;
        else if (load)  addr <= load_val;
        else if (step) begin
            case (mode)
                AS_INC:  addr <= addr + STEP_V;
                AS_DEC:  addr <= addr - STEP_V;
                default: addr <= addr;
            endcase
        end
    end

    // R2: a fixed address never moves on a step.
    p_fixed_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == AS_FIXED) |=> addr == $past(addr));
endmodule

// File: rtl/dma_seq_chan.sv
// One DMA channel sequencer. It runs dual-address transfers (a read, then a
// write) in plain cycle-steal, gapped cycle-steal or burst bus mode, and
// handles bus request and release and the transfer count.
// Assumes: the configuration inputs are sampled only on an accepted start;
// the grant stays high while bus_req is high.
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int         AW            = 32,
    parameter int         DW            = 32,
    parameter int         CW            = 16,
    parameter int         STEP          = 4,
    parameter int         GAP_SHORT     = 16,
    parameter int         GAP_LONG      = 64,
    parameter logic [7:0] BURST_OK_MASK = 8'b0001_1111
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_src,
    input  logic [AW-1:0] start_dst,
    input  logic [CW-1:0] start_count,
    input  logic [1:0]    cfg_bus_mode,
    input  logic          cfg_gap_long,
    input  logic          cfg_req_ext,
    input  logic [2:0]    cfg_src_id,
    input  logic [1:0]    cfg_src_step,
    input  logic [1:0]    cfg_dst_step,
    input  logic          ext_req_n,
    input  logic          periph_req,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          cmd_valid,
    output logic          cmd_write,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_wdata,
    input  logic          cmd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic [CW-1:0] count_left,
    output logic          done_pulse
);
    localparam logic [CW-1:0] ONE = CW'(1);

    seq_state_e    state_q, state_d;
    bus_mode_e     mode_q, mode_start;
    addr_step_e    src_mode_q, dst_mode_q;
    logic          ext_sel_q, gap_long_q;
    logic [CW-1:0] count_q;
    logic [DW-1:0] data_q;
    logic          busy_q;
    logic          done_q;
    logic          start_fire, launch, rd_done, wr_done, last_xfer;
    logic          keep_bus, req_active, gap_active, gap_load;
    logic          burst_ok;
    logic [AW-1:0] src_addr, dst_addr;

    // Accept a start only when idle and with a nonzero count.
    assign start_fire = start && !busy_q && (start_count != '0);

    // Burst is allowed for the external line or for listed on-chip sources.
    assign burst_ok = cfg_req_ext || BURST_OK_MASK[cfg_src_id];

    // Resolve the mode used for this run, demoting burst when not allowed.
    always_comb begin
        case (cfg_bus_mode)
            2'd1:    mode_start = BM_GAPPED;
            2'd2:    mode_start = burst_ok ? BM_BURST : BM_STEAL;
            default: mode_start = BM_STEAL;
        endcase
    end

    // Latch the per-run configuration on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= BM_STEAL;
            ext_sel_q  <= 1'b0;
            gap_long_q <= 1'b0;
            src_mode_q <= AS_FIXED;
            dst_mode_q <= AS_FIXED;
        end else if (start_fire) begin
            mode_q     <= mode_start;
            ext_sel_q  <= cfg_req_ext;
            gap_long_q <= cfg_gap_long;
            src_mode_q <= addr_step_e'(cfg_src_step);
            dst_mode_q <= addr_step_e'(cfg_dst_step);
        end
    end

    dma_req_detect u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_ext    (ext_sel_q),
        .ext_req_n  (ext_req_n),
        .periph_req (periph_req),
        .accept     (launch),
        .req_active (req_active)
    );

    dma_gap_timer #(
        .GAP_SHORT (GAP_SHORT),
        .GAP_LONG  (GAP_LONG)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .long_sel (gap_long_q),
        .active   (gap_active)
    );

    // A transfer starts from idle only when enabled, out of a gap and requested.
    assign launch    = (state_q == SQ_IDLE) && busy_q && !gap_active && req_active;
    assign rd_done   = (state_q == SQ_READ) && cmd_ready;
    assign wr_done   = (state_q == SQ_WRITE) && cmd_ready;
    assign last_xfer = (count_q == ONE);
    // Burst continues while the external level is held; on-chip bursts run to the end.
    assign keep_bus  = (mode_q == BM_BURST) && (!ext_sel_q || req_active);
    assign gap_load  = wr_done && !last_xfer && (mode_q == BM_GAPPED);

    // Next-state logic for the bus sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:  if (launch)  state_d = SQ_ARB;
            SQ_ARB:   if (bus_gnt) state_d = SQ_READ;
            SQ_READ:  if (cmd_ready) state_d = SQ_WRITE;
            SQ_WRITE: if (cmd_ready)
                          state_d = (!last_xfer && keep_bus) ? SQ_READ : SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Channel enable, transfer count and end pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= wr_done && last_xfer;
            if (start_fire) begin
                busy_q  <= 1'b1;
                count_q <= start_count;
            end else if (wr_done) begin
                count_q <= count_q - ONE;
                if (last_xfer) busy_q <= 1'b0;
            end
        end
    end

    // Capture read data for the following write.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_done) data_q <= rd_data;
    end

    dma_addr_step #(.AW(AW), .STEP(STEP)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_fire),
        .load_val (start_src),
        .step     (rd_done),
        .mode     (src_mode_q),
        .addr     (src_addr)
    );

    dma_addr_step #(.AW(AW), .STEP(STEP)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_fire),
        .load_val (start_dst),
        .step     (wr_done),
        .mode     (dst_mode_q),
        .addr     (dst_addr)
    );

    assign bus_req    = (state_q != SQ_IDLE);
    assign cmd_valid  = (state_q == SQ_READ) || (state_q == SQ_WRITE);
    assign cmd_write  = (state_q == SQ_WRITE);
    assign cmd_addr   = cmd_write ? dst_addr : src_addr;
    assign cmd_wdata  = data_q;
    assign busy       = busy_q;
    assign count_left = count_q;
    assign done_pulse = done_q;

    // R11: bus commands only while granted.
    p_cmd_owns_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> bus_gnt);
    // R3: end pulse lasts one cycle.
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R3: at the end pulse the bus is free and the channel is off.
    p_done_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!bus_req && !busy));
    // R3: the count only steps down by one unless reloaded.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_fire |=> (count_q == $past(count_q) || count_q == $past(count_q) - ONE));
    // R5: no bus request while the idle gap runs.
    p_gap_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_active |-> !bus_req);
    // R4: non-burst modes give up the bus after each write.
    p_steal_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && mode_q != BM_BURST) |=> !bus_req);
    // R6: an on-chip burst keeps the bus until the last write.
    p_burst_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !last_xfer && mode_q == BM_BURST && !ext_sel_q) |=> bus_req);
endmodule

// File: tb/sim_dma_seq_chan.sv
`timescale 1ns/1ps
module sim_dma_seq_chan;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam logic [DW-1:0] RD_KEY = 32'h5A5A_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_src = '0;
    logic [AW-1:0] start_dst = '0;
    logic [CW-1:0] start_count = '0;
    logic [1:0]    cfg_bus_mode = 2'd0;
    logic          cfg_gap_long = 1'b0;
    logic          cfg_req_ext = 1'b1;
    logic [2:0]    cfg_src_id = 3'd0;
    logic [1:0]    cfg_src_step = 2'd1;
    logic [1:0]    cfg_dst_step = 2'd1;
    logic          ext_req_n = 1'b1;
    logic          periph_req = 1'b0;
    logic          bus_req, bus_gnt, cmd_valid, cmd_write, cmd_ready;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata, rd_data;
    logic          busy, done_pulse;
    logic [CW-1:0] count_left;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    // Simple bus model: grant follows request by one clock, zero wait states.
    always @(posedge clk) bus_gnt <= rst_n ? bus_req : 1'b0;
    assign cmd_ready = 1'b1;
    assign rd_data   = cmd_addr ^ RD_KEY;

    dma_seq_chan u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_src(start_src),
        .start_dst(start_dst), .start_count(start_count),
        .cfg_bus_mode(cfg_bus_mode), .cfg_gap_long(cfg_gap_long),
        .cfg_req_ext(cfg_req_ext), .cfg_src_id(cfg_src_id),
        .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
        .ext_req_n(ext_req_n), .periph_req(periph_req),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .cmd_valid(cmd_valid),
        .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_ready(cmd_ready), .rd_data(rd_data), .busy(busy),
        .count_left(count_left), .done_pulse(done_pulse)
    );

    // Bus activity log, sampled on the falling edge.
    logic [AW-1:0] rd_log [0:15];
    logic [AW-1:0] wr_log [0:15];
    logic [DW-1:0] wd_log [0:15];
    int gaps [0:15];
    int rd_n, wr_n, gap_n, rises, done_n, low_run;
    logic prev_req, had_high;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_write && wr_n < 16) begin
                wr_log[wr_n] = cmd_addr;
                wd_log[wr_n] = cmd_wdata;
                wr_n++;
            end else if (cmd_valid && !cmd_write && rd_n < 16) begin
                rd_log[rd_n] = cmd_addr;
                rd_n++;
            end
            if (done_pulse) done_n++;
            if (bus_req && !prev_req) begin
                rises++;
                if (had_high && gap_n < 16) begin
                    gaps[gap_n] = low_run;
                    gap_n++;
                end
            end
            if (bus_req) begin
                had_high = 1'b1;
                low_run  = 0;
            end else begin
                low_run++;
            end
            prev_req = bus_req;
        end
    end

    task automatic clear_log();
        @(negedge clk);
        rd_n = 0; wr_n = 0; gap_n = 0; rises = 0; done_n = 0;
        low_run = 0; had_high = 1'b0; prev_req = bus_req;
    endtask

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic kick(input logic [1:0] mode, input logic gl, input logic ext,
                        input logic [2:0] id, input logic [1:0] ss, input logic [1:0] ds,
                        input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input logic [CW-1:0] n);
        @(negedge clk);
        cfg_bus_mode = mode; cfg_gap_long = gl; cfg_req_ext = ext; cfg_src_id = id;
        cfg_src_step = ss; cfg_dst_step = ds; start_src = s; start_dst = d;
        start_count = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_periph();
        @(negedge clk); periph_req = 1'b1;
        @(negedge clk); periph_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!bus_req && !busy && !cmd_valid && !done_pulse && count_left == 0,
            "R3 reset state", {bus_req, busy, cmd_valid, done_pulse}, 0);
    endtask

    task automatic t_steal();
        clear_log();
        ext_req_n = 1'b0;
        kick(2'd0, 1'b0, 1'b1, 3'd0, 2'd1, 2'd1, 32'h100, 32'h200, 16'd3);
        wait_idle();
        ext_req_n = 1'b1;
        chk(rd_n == 3 && wr_n == 3, "R1 three read/write pairs", wr_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk(rd_log[i] == 32'h100 + 4 * i, "R2 source increment", rd_log[i], 32'h100 + 4 * i);
            chk(wr_log[i] == 32'h200 + 4 * i, "R2 destination increment", wr_log[i], 32'h200 + 4 * i);
            chk(wd_log[i] == ((32'h100 + 4 * i) ^ RD_KEY), "R1 write carries read data",
                wd_log[i], (32'h100 + 4 * i) ^ RD_KEY);
        end
        chk(rises == 3, "R4 bus released per transfer", rises, 3);
        chk(gap_n == 2 && gaps[0] == 1 && gaps[1] == 1, "R4 one-cycle release", gaps[0], 1);
        chk(done_n == 1 && count_left == 0 && !busy, "R3 end of count", done_n, 1);
    endtask

    task automatic t_gapped(input logic gl);
        int exp_gap;
        exp_gap = gl ? 65 : 17;
        clear_log();
        ext_req_n = 1'b0;
        kick(2'd1, gl, 1'b1, 3'd0, 2'd1, 2'd1, 32'h500, 32'h600, 16'd2);
        wait_idle();
        ext_req_n = 1'b1;
        chk(wr_n == 2, "R5 gapped transfers done", wr_n, 2);
        chk(gap_n == 1 && gaps[0] == exp_gap, "R5 idle gap length", gaps[0], exp_gap);
    endtask

    task automatic t_burst_ext();
        clear_log();
        ext_req_n = 1'b0;
        kick(2'd2, 1'b0, 1'b1, 3'd0, 2'd1, 2'd1, 32'h700, 32'h800, 16'd4);
        wait_idle();
        ext_req_n = 1'b1;
        chk(wr_n == 4 && rises == 1, "R6 burst holds bus", rises, 1);
        chk(done_n == 1, "R3 burst end pulse", done_n, 1);
    endtask

    task automatic t_burst_early();
        clear_log();
        ext_req_n = 1'b0;
        kick(2'd2, 1'b0, 1'b1, 3'd0, 2'd1, 2'd1, 32'h900, 32'hA00, 16'd5);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cmd_valid && !cmd_write) break;
        end
        ext_req_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(wr_n == 1, "R7 accepted transfer completes", wr_n, 1);
        chk(count_left == 4 && busy && !bus_req, "R7 early release", count_left, 4);
        ext_req_n = 1'b0;
        wait_idle();
        ext_req_n = 1'b1;
        chk(wr_n == 5 && rises == 2, "R7 resume after release", rises, 2);
    endtask

    task automatic t_onchip();
        clear_log();
        kick(2'd2, 1'b0, 1'b0, 3'd2, 2'd1, 2'd1, 32'hB00, 32'hC00, 16'd3);
        pulse_periph();
        wait_idle();
        chk(wr_n == 3 && rises == 1, "R8 listed source bursts", rises, 1);
        clear_log();
        kick(2'd2, 1'b0, 1'b0, 3'd6, 2'd1, 2'd1, 32'hD00, 32'hE00, 16'd3);
        repeat (10) @(negedge clk);
        chk(wr_n == 0 && !bus_req, "R9 no transfer without edge", wr_n, 0);
        pulse_periph();
        repeat (20) @(negedge clk);
        chk(wr_n == 1 && count_left == 2 && !bus_req, "R8 unlisted source one transfer", wr_n, 1);
        pulse_periph();
        repeat (20) @(negedge clk);
        pulse_periph();
        wait_idle();
        chk(wr_n == 3 && rises == 3 && !busy, "R8 unlisted source per-request", rises, 3);
    endtask

    task automatic t_pending_gap();
        clear_log();
        kick(2'd1, 1'b0, 1'b0, 3'd0, 2'd1, 2'd1, 32'h1000, 32'h2000, 16'd2);
        pulse_periph();
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (cmd_valid && cmd_write) break;
        end
        repeat (3) @(negedge clk);
        pulse_periph();
        wait_idle();
        chk(wr_n == 2 && gap_n == 1 && gaps[0] == 17, "R9 pending held through gap", gaps[0], 17);
    endtask

    task automatic t_modes();
        clear_log();
        ext_req_n = 1'b0;
        kick(2'd0, 1'b0, 1'b1, 3'd0, 2'd0, 2'd2, 32'h300, 32'h400, 16'd3);
        wait_idle();
        ext_req_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk(rd_log[i] == 32'h300, "R2 fixed source", rd_log[i], 32'h300);
            chk(wr_log[i] == 32'h400 - 4 * i, "R2 destination decrement", wr_log[i], 32'h400 - 4 * i);
        end
    endtask

    task automatic t_zero();
        clear_log();
        ext_req_n = 1'b0;
        kick(2'd0, 1'b0, 1'b1, 3'd0, 2'd1, 2'd1, 32'h0, 32'h0, 16'd0);
        repeat (10) @(negedge clk);
        ext_req_n = 1'b1;
        chk(!busy && rises == 0 && count_left == 0, "R10 zero count ignored", rises, 0);
    endtask

    task automatic t_start_busy();
        clear_log();
        kick(2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 2'd1, 32'h4000, 32'h5000, 16'd2);
        kick(2'd0, 1'b0, 1'b0, 3'd0, 2'd1, 2'd1, 32'h6000, 32'h7000, 16'd9);
        chk(count_left == 2, "R10 start while busy ignored", count_left, 2);
        pulse_periph();
        repeat (10) @(negedge clk);
        pulse_periph();
        wait_idle();
        chk(wr_n == 2 && rd_log[0] == 32'h4000, "R10 original run kept", rd_log[0], 32'h4000);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_steal();
        t_gapped(1'b0);
        t_gapped(1'b1);
        t_burst_ext();
        t_burst_early();
        t_onchip();
        t_pending_gap();
        t_modes();
        t_zero();
        t_start_busy();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule